// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Block

This block collects interrupt requests from up to 32 sources and presents them to a processor core on two active-low request lines: a fast line owned only by source 0, and a normal line shared by sources 1 through 17. Each source has a pending bit and a mask bit. A request reaches a line only when both bits are set.

Peripherals raise a source by pulsing its bit on a set-strobe vector for one cycle. Software reaches the block over a simple word-wide register bus. It sets mask bits through an enable command and drops them through a disable command. It clears pending bits through either a clear command or an end-of-interrupt command. Software reads a vector register to learn which source to serve. That read returns the lowest-numbered pending source and acknowledges it in the same access. The last value returned by the vector register is held, so a later status read can find out which source is being served.

Read data is combinational during the cycle in which the bus is selected with write low. Every register update, including the acknowledge side effect of a vector read, takes place at the rising clock edge that ends the access. The request lines follow the registered state.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the pending, mask and held-vector registers are zero, and both `fiq_n` and `irq_n` are high.
- R2: A 1 on bit i of `src_set` sets pending bit i at the next edge. If a clear command in the same cycle names the same bit, the set wins and the bit stays pending.
- R3: A write to offset 0x20 ORs the write data into the mask. A write to offset 0x24 clears every mask bit that is 1 in the write data.
- R4: A write to offset 0x28 or to offset 0x30 clears every pending bit that is 1 in the write data.
- R5: `fiq_n` is low exactly when bit 0 is set in both pending and mask. `irq_n` is low exactly when pending AND mask has any bit set in positions 1 through 17. Bits 18 through 31 drive neither line.
- R6: A read of offset 0x00 returns, zero-extended, the index of the lowest pending bit. The mask is not considered. The same read clears that pending bit at the end of the access.
- R7: A read of offset 0x00 with no bit pending returns 0 and leaves the pending and mask registers unchanged.
- R8: Every read of offset 0x00 stores the value it returned. A read of offset 0x08 returns that stored value, zero-extended.
- R9: Reads of offsets 0x10, 0x14 and 0x20 return the current mask. A read of any other offset, including 0x24, 0x28 and 0x30, returns all ones. Writes to offsets other than 0x20, 0x24, 0x28 and 0x30 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high and bus_wr is low |
| src_set | input | 32 | Per-source one-cycle set strobes |
| fiq_n | output | 1 | Fast interrupt request, active low |
| irq_n | output | 1 | Normal interrupt request, active low |

## Verification
The vector register is exercised with several pending patterns: a single source, sources 0 and 2 together, a masked-only source, source 31 alone, and an empty set. Together these show that the scan picks the lowest index, ignores the mask, clears only the chosen bit, and returns 0 with no side effect when nothing is pending. The request lines are driven with sources 0, 2, 17 and 18, masked and unmasked. This separates the fast-line bit from the normal range and shows that bit 18 lies outside the normal range. Clear commands are issued both alone and together with a set strobe on the same bit, which shows that clearing works and that the set takes precedence.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // register byte offsets
  localparam int OFS_VECTOR  = 'h00;
  localparam int OFS_STATUS  = 'h08;
  localparam int OFS_MASK    = 'h10;
  localparam int OFS_CORE    = 'h14;
  localparam int OFS_ENABLE  = 'h20;
  localparam int OFS_DISABLE = 'h24;
  localparam int OFS_CLEAR   = 'h28;
  localparam int OFS_EOI     = 'h30;

  typedef struct packed {
    logic rd_vec;    // vector read (acknowledge)
    logic rd_stat;   // held vector read
    logic rd_mask;   // any of the mask views
    logic rd_none;   // unmapped read
    logic wr_en;     // OR into mask
    logic wr_dis;    // clear mask bits
    logic wr_clr;    // clear pending bits (clear or end-of-interrupt)
  } acc_t;

endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc
);
  logic rd, wr_acc;
  logic hit_vec, hit_stat, hit_mask, hit_en, hit_dis, hit_clr;

  always_comb begin
    rd       = sel & ~wr;
    wr_acc   = sel & wr;
    hit_vec  = (addr == ADDR_W'(OFS_VECTOR));
    hit_stat = (addr == ADDR_W'(OFS_STATUS));
    hit_en   = (addr == ADDR_W'(OFS_ENABLE));
    hit_mask = (addr == ADDR_W'(OFS_MASK)) | (addr == ADDR_W'(OFS_CORE)) | hit_en;
    hit_dis  = (addr == ADDR_W'(OFS_DISABLE));
    hit_clr  = (addr == ADDR_W'(OFS_CLEAR)) | (addr == ADDR_W'(OFS_EOI));

    acc.rd_vec  = rd & hit_vec;
    acc.rd_stat = rd & hit_stat;
    acc.rd_mask = rd & hit_mask;
    acc.rd_none = rd & ~(hit_vec | hit_stat | hit_mask);
    acc.wr_en   = wr_acc & hit_en;
    acc.wr_dis  = wr_acc & hit_dis;
    acc.wr_clr  = wr_acc & hit_clr;
  end
endmodule

// File: rtl/irqc_lowest_scan.sv
module irqc_lowest_scan #(
  parameter int N_SRC = 32,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] vec,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N_SRC-1:0] onehot
);
  // isolate the lowest set bit, then encode it
  assign onehot = vec & (~vec + {{(N_SRC-1){1'b0}}, 1'b1});
  assign any    = |vec;

  genvar b;
  generate
    for (b = 0; b < IDX_W; b++) begin : g_enc
      logic [N_SRC-1:0] col;
      always_comb begin
        for (int i = 0; i < N_SRC; i++) col[i] = ((i >> b) & 1) == 1;
      end
      assign idx[b] = |(onehot & col);
    end
  endgenerate
endmodule

// File: rtl/irqc_pend_reg.sv
module irqc_pend_reg #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set,
  input  logic [N_SRC-1:0] clr,
  output logic [N_SRC-1:0] q
);
  logic [N_SRC-1:0] q_nx;
  logic             upd;

  always_comb begin
    upd  = (|set) | (|clr);
    q_nx = (q & ~clr) | set;   // set has priority over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= q_nx;
  end

  // R2
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((q & $past(set)) == $past(set)));

  // R4
  clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr) |=> ((q & $past(clr) & ~$past(set)) == '0));
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_w,
  input  logic             dis_w,
  input  logic [N_SRC-1:0] data,
  output logic [N_SRC-1:0] q
);
  logic [N_SRC-1:0] q_nx;
  logic             upd;

  always_comb begin
    upd  = en_w | dis_w;
    q_nx = q;
    if (en_w)  q_nx = q | data;
    if (dis_w) q_nx = q & ~data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= q_nx;
  end

  // R3
  mask_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_w |=> ((q & $past(data)) == $past(data)));

  // R3
  mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_w |=> ((q & $past(data)) == '0));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int N_SRC   = 32,
  parameter int ADDR_W  = 8,
  parameter int NORM_LO = 1,
  parameter int NORM_HI = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  input  logic [N_SRC-1:0]  src_set,
  output logic              fiq_n,
  output logic              irq_n
);
  localparam int IDX_W = $clog2(N_SRC);

  logic             rst_n_s;
  acc_t             acc;
  logic [N_SRC-1:0] pend_q, mask_q, act;
  logic [N_SRC-1:0] scan_oh, pend_clr;
  logic [IDX_W-1:0] scan_idx, vec_ret, vec_lat, vec_lat_nx;
  logic             scan_any, vec_take;

  irqc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  irqc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .acc(acc));

  irqc_lowest_scan #(.N_SRC(N_SRC)) u_scan (
    .vec(pend_q), .any(scan_any), .idx(scan_idx), .onehot(scan_oh));

  always_comb begin
    vec_take = acc.rd_vec & scan_any;
    vec_ret  = scan_any ? scan_idx : '0;
    pend_clr = (acc.wr_clr ? bus_wdata : '0) | (vec_take ? scan_oh : '0);
  end

  irqc_pend_reg #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n_s), .set(src_set), .clr(pend_clr), .q(pend_q));

  irqc_mask_reg #(.N_SRC(N_SRC)) u_mask (
    .clk(clk), .rst_n(rst_n_s), .en_w(acc.wr_en), .dis_w(acc.wr_dis),
    .data(bus_wdata), .q(mask_q));

  // held vector
  always_comb vec_lat_nx = vec_ret;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)        vec_lat <= '0;
    else if (acc.rd_vec) vec_lat <= vec_lat_nx;
  end

  // read data
  always_comb begin
    bus_rdata = '0;
    if (acc.rd_vec)  bus_rdata = {{(N_SRC-IDX_W){1'b0}}, vec_ret};
    if (acc.rd_stat) bus_rdata = {{(N_SRC-IDX_W){1'b0}}, vec_lat};
    if (acc.rd_mask) bus_rdata = mask_q;
    if (acc.rd_none) bus_rdata = '1;
  end

  // request lines
  always_comb begin
    act   = pend_q & mask_q;
    fiq_n = ~act[0];
    irq_n = ~(|act[NORM_HI:NORM_LO]);
  end

  // R8
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    acc.rd_vec |=> (vec_lat == $past(bus_rdata[IDX_W-1:0])));

  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc.rd_vec && !scan_any && src_set == '0) |=> ($stable(pend_q) && $stable(mask_q)));

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (vec_take && ((src_set & scan_oh) == '0)) |=> ((pend_q & $past(scan_oh)) == '0));

  // R5
  fast_line_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(fiq_n) |-> ($past(src_set[0]) || $past(acc.wr_en)));
endmodule

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, src_set;
  logic        fiq_n, irq_n;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  // bench model built from the requirements
  logic [31:0] m_pend = '0;
  logic [31:0] m_mask = '0;
  logic [31:0] m_lat  = '0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_set(src_set), .fiq_n(fiq_n), .irq_n(irq_n));

  // monitor: compare read data against the scoreboard
  always @(negedge clk) begin
    if (bus_sel && !bus_wr) begin
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual %h expected none", bus_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (bus_rdata !== e.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", e.tag, bus_rdata, e.exp);
        end
      end
    end
  end

  task automatic bus_rd(input logic [7:0] a, input string tag);
    exp_t e;
    e.tag = tag;
    case (a)
      8'h00: begin
        e.exp = 32'd0;
        for (int i = 31; i >= 0; i--) if (m_pend[i]) e.exp = i;
        if (m_pend != 0) m_pend[e.exp[4:0]] = 1'b0;
        m_lat = e.exp;
      end
      8'h08: e.exp = m_lat;
      8'h10, 8'h14, 8'h20: e.exp = m_mask;
      default: e.exp = 32'hffff_ffff;
    endcase
    sb_q.push_back(e);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic bus_wrt(input logic [7:0] a, input logic [31:0] d, input logic [31:0] s);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; src_set = s;
    case (a)
      8'h20: m_mask = m_mask | d;
      8'h24: m_mask = m_mask & ~d;
      8'h28, 8'h30: m_pend = m_pend & ~d;
      default: ;
    endcase
    m_pend = m_pend | s;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; src_set = '0;
  endtask

  task automatic raise(input logic [31:0] s);
    @(posedge clk); #1;
    src_set = s;
    m_pend = m_pend | s;
    @(posedge clk); #1;
    src_set = '0;
  endtask

  task automatic chk_lines(input string tag);
    logic ef, ei;
    @(negedge clk);
    ef = !(m_pend[0] & m_mask[0]);
    ei = !(|(m_pend[17:1] & m_mask[17:1]));
    checks++;
    if (fiq_n !== ef || irq_n !== ei) begin
      errors++;
      $display("FAIL %s: actual fiq_n=%b irq_n=%b expected fiq_n=%b irq_n=%b",
               tag, fiq_n, irq_n, ef, ei);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; src_set = '0;
    repeat (4) @(posedge clk);
    chk_lines("R1 lines during reset");
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk_lines("R1 lines after reset");
    bus_rd(8'h10, "R1 mask zero");
    bus_rd(8'h08, "R1 held vector zero");
    bus_rd(8'h00, "R7 empty vector read");
    chk_lines("R7 lines after empty read");
    bus_rd(8'h10, "R7 mask unchanged");

    raise(32'h0000_0005);
    chk_lines("R5 pending but masked");
    bus_wrt(8'h20, 32'h1, 32'h0);
    chk_lines("R5 fast line from bit 0");
    bus_rd(8'h14, "R9 core view of mask");
    bus_rd(8'h20, "R9 enable view of mask");
    bus_wrt(8'h20, 32'h4, 32'h0);
    bus_rd(8'h10, "R3 enable ORs");
    chk_lines("R5 normal line from bit 2");
    bus_rd(8'h00, "R6 lowest index 0");
    chk_lines("R6 fast line released by ack");
    bus_rd(8'h00, "R6 next index 2");
    bus_rd(8'h08, "R8 held vector 2");
    chk_lines("R6 both lines released");
    bus_rd(8'h00, "R7 empty after drain");
    bus_rd(8'h08, "R8 held vector after empty read");

    bus_wrt(8'h20, 32'h0006_0000, 32'h0);
    raise(32'h0004_0000);
    chk_lines("R5 bit 18 drives no line");
    raise(32'h0002_0000);
    chk_lines("R5 bit 17 drives normal line");
    bus_wrt(8'h28, 32'h0002_0000, 32'h0);
    chk_lines("R4 clear command");
    raise(32'h0002_0000);
    bus_wrt(8'h30, 32'h0002_0000, 32'h0);
    chk_lines("R4 end-of-interrupt command");
    bus_wrt(8'h28, 32'h0002_0000, 32'h0002_0000);
    chk_lines("R2 set wins over clear");
    bus_wrt(8'h24, 32'h0002_0000, 32'h0);
    chk_lines("R3 disable drops mask bit");
    bus_rd(8'h10, "R3 mask after disable");

    bus_wrt(8'h28, 32'hffff_ffff, 32'h0);
    raise(32'h0000_0020);
    bus_rd(8'h00, "R6 masked source still returned");
    raise(32'h8000_0000);
    bus_rd(8'h00, "R6 top index 31");
    bus_rd(8'h08, "R8 held vector 31");
    bus_wrt(8'h04, 32'hffff_ffff, 32'h0);
    bus_rd(8'h10, "R9 unmapped write ignored");
    bus_rd(8'h04, "R9 unmapped read");
    bus_rd(8'h24, "R9 disable offset reads ones");
    bus_rd(8'h30, "R9 end-of-interrupt offset reads ones");
    chk_lines("R5 final lines");

    repeat (3) @(posedge clk);
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule